// File: doc/BRIEF.md
# Receive FIFO with Programmable Flow-Control Triggers

This block buffers bytes arriving from a serial receiver until the CPU reads them. It also watches how full the buffer is and reports this in two ways. A latched data-ready flag tells software that enough bytes are waiting. A request-to-send style level tells the remote sender to pause before the buffer overflows.

Both fill limits come from one 16-bit control word that the CPU writes. The limits are chosen from small code tables, and each uses its own comparison rule. The same word also carries these bits:
- a receive-flush bit;
- a transmit-flush bit;
- a loopback bit;
- a two-bit transmit trigger.

The transmit-flush, loopback and transmit-trigger bits only pass through to neighbouring logic.

The receiver pushes one byte per cycle into the FIFO. The CPU pops bytes through a read strobe. The head byte is visible combinationally on the read data port, and it shows zero when the FIFO is empty.

Top module: `rx_fifo_flowctl`

## Requirements
- R1: After reset the control word reads 0x0000. Bits 15:11 always read 0 and ignore writes. Bits 10:0 read back the last value written.
- R2: Control bits 10:8 pick the flow-control limit as follows: 0→63, 1→1, 2→8, 3→16, 4→32, 5→48, 6→54, 7→60.
- R3: `rts_level` is 1 exactly when the stored byte count is strictly above the selected flow-control limit. It follows the count one clock after the count changes.
- R4: Control bits 7:6 pick the ready limit as follows: 0→1, 1→16, 2→32, 3→48.
- R5: `data_ready` is set one clock after the stored count is greater than or equal to the ready limit.
- R6: Once `data_ready` is set, it stays 1 until a `flag_clr` pulse arrives while the count is below the ready limit. A pulse while the count is at or above the limit has no effect.
- R7: While control bit 1 (receive flush) is 1, the count is held at 0, incoming bytes are discarded and the overrun flag is cleared.
- R8: The FIFO holds 64 bytes and returns them in arrival order. `rx_count` ranges from 0 to 64.
- R9: A byte written while the FIFO is full is dropped, the count stays at 64 and `overrun` is set. `overrun` stays set until a flush.
- R10: A read from an empty FIFO returns 0x00 and leaves the count at 0. A simultaneous read and write on a FIFO that is neither empty nor full leaves the count unchanged.
- R11: Control bit 0 drives `loop_en`, bit 2 drives `tx_clear` and bits 5:4 drive `tx_trig`, all directly and unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Byte push strobe from the receiver |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Byte pop strobe from the CPU |
| rd_data | output | 8 | Head byte, or 0x00 when empty |
| reg_we | input | 1 | Control word write strobe |
| reg_wdata | input | 16 | Control word write value |
| reg_rdata | output | 16 | Control word read value |
| flag_clr | input | 1 | Request to clear the ready flag |
| rx_count | output | 7 | Number of stored bytes |
| data_ready | output | 1 | Latched ready flag |
| rts_level | output | 1 | Flow-control level |
| overrun | output | 1 | Sticky dropped-byte flag |
| tx_clear | output | 1 | Transmit-flush control bit |
| loop_en | output | 1 | Loopback control bit |
| tx_trig | output | 2 | Transmit trigger code |

## Verification
The embedded properties check several rules on every cycle:
- the reserved bits stay zero;
- a full FIFO drops writes and raises overrun;
- an empty read keeps the count at zero;
- a flush empties the FIFO;
- the flow-control and ready outputs follow the count against the decoded limit one clock later;
- the ready flag holds until a clear arrives.

Only the bench scenarios can show the rest. These are the exact limit values behind each code, the arrival order of bytes across pointer wraparound, and the difference between the `>` and `>=` rules at the boundary counts. They also cover a clear pulse being ignored above the ready limit, and the pass-through control bits.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

   // Control word layout; reserved field is forced to zero on write.
   typedef struct packed {
      logic [4:0] rsv;
      logic [2:0] rts_sel;
      logic [1:0] rdy_sel;
      logic [1:0] tx_trig;
      logic       spare;
      logic       tx_clr;
      logic       rx_clr;
      logic       loop_en;
   } ctl_t;

   localparam logic [15:0] CTL_WMASK = 16'h07FF;

   // Flow-control limit; code 0 selects the top of the table.
   function automatic logic [6:0] rts_limit(input logic [2:0] code);
      case (code)
         3'd1:    rts_limit = 7'd1;
         3'd2:    rts_limit = 7'd8;
         3'd3:    rts_limit = 7'd16;
         3'd4:    rts_limit = 7'd32;
         3'd5:    rts_limit = 7'd48;
         3'd6:    rts_limit = 7'd54;
         3'd7:    rts_limit = 7'd60;
         default: rts_limit = 7'd63;
      endcase
   endfunction

   function automatic logic [6:0] rdy_limit(input logic [1:0] code);
      case (code)
         2'd1:    rdy_limit = 7'd16;
         2'd2:    rdy_limit = 7'd32;
         2'd3:    rdy_limit = 7'd48;
         default: rdy_limit = 7'd1;
      endcase
   endfunction

endpackage

// File: rtl/rxf_ctrl_reg.sv
module rxf_ctrl_reg
   import rxf_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [15:0] wdata,
   output ctl_t        ctl
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl <= '0;
      end else if (we) begin
         ctl <= ctl_t'(wdata & CTL_WMASK);
      end
   end

   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctl.rsv == 5'd0); // R1

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   output logic [CW-1:0] count,
   output logic          overrun
);

   generate
      if (DEPTH < 64) begin : g_depth_chk
         $error("rxf_store: DEPTH must cover the largest limit (64)");
      end
      if (DW < 1) begin : g_dw_chk
         $error("rxf_store: DW must be positive");
      end
   endgenerate

   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic          full, empty, push, pop;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign push  = wr_en && !full && !flush;
   assign pop   = rd_en && !empty && !flush;

   // Pointer wrap: free-running for powers of two, compare otherwise.
   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_wrap_pow2
         assign wr_nxt = wr_ptr + 1'b1;
         assign rd_nxt = rd_ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else if (flush) begin
         wr_ptr  <= '0;
         rd_ptr  <= '0;
         count   <= '0;
         overrun <= 1'b0;
      end else begin
         if (push) wr_ptr <= wr_nxt;
         if (pop)  rd_ptr <= rd_nxt;
         if (push && !pop)      count <= count + 1'b1;
         else if (pop && !push) count <= count - 1'b1;
         if (wr_en && full) overrun <= 1'b1;
      end
   end

   assign rd_data = empty ? '0 : mem[rd_ptr];

   AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH)); // R8
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (full && wr_en && !rd_en && !flush) |=> (count == CW'(DEPTH) && overrun)); // R9
   AST_EMPTY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && rd_en && !wr_en && !flush) |=> (count == '0)); // R10
   AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (count == '0 && !overrun)); // R7
   AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      empty |-> (rd_data == '0)); // R10

endmodule

// File: rtl/rxf_trigger.sv
module rxf_trigger #(
   parameter int CW = 7
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [CW-1:0] count,
   input  logic [2:0]    rts_sel,
   input  logic [1:0]    rdy_sel,
   input  logic          flag_clr,
   output logic          ready,
   output logic          rts
);

   generate
      if (CW < 7) begin : g_cw_chk
         $error("rxf_trigger: count width too small for the limit tables");
      end
   endgenerate

   logic [CW-1:0] rts_thr, rdy_thr;
   logic          above_rts, at_rdy;

   assign rts_thr   = CW'(rxf_pkg::rts_limit(rts_sel));
   assign rdy_thr   = CW'(rxf_pkg::rdy_limit(rdy_sel));
   assign above_rts = (count > rts_thr);
   assign at_rdy    = (count >= rdy_thr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts   <= 1'b0;
         ready <= 1'b0;
      end else begin
         rts   <= above_rts;
         ready <= at_rdy || (ready && !flag_clr);
      end
   end

   AST_RTS_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (count > rts_thr) |=> rts); // R3
   AST_READY_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (count >= rdy_thr) |=> ready); // R5
   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !flag_clr) |=> ready); // R6

endmodule

// File: rtl/rx_fifo_flowctl.sv
module rx_fifo_flowctl #(
   parameter int DW    = 8,
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wr_data,
   input  logic          rd_en,
   output logic [DW-1:0] rd_data,
   input  logic          reg_we,
   input  logic [15:0]   reg_wdata,
   output logic [15:0]   reg_rdata,
   input  logic          flag_clr,
   output logic [CW-1:0] rx_count,
   output logic          data_ready,
   output logic          rts_level,
   output logic          overrun,
   output logic          tx_clear,
   output logic          loop_en,
   output logic [1:0]    tx_trig
);

   rxf_pkg::ctl_t ctl;

   rxf_ctrl_reg u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (reg_we),
      .wdata (reg_wdata),
      .ctl   (ctl)
   );

   rxf_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .flush   (ctl.rx_clr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .count   (rx_count),
      .overrun (overrun)
   );

   rxf_trigger #(.CW(CW)) u_trig (
      .clk      (clk),
      .rst_n    (rst_n),
      .count    (rx_count),
      .rts_sel  (ctl.rts_sel),
      .rdy_sel  (ctl.rdy_sel),
      .flag_clr (flag_clr),
      .ready    (data_ready),
      .rts      (rts_level)
   );

   assign reg_rdata = ctl;
   assign tx_clear  = ctl.tx_clr;
   assign loop_en   = ctl.loop_en;
   assign tx_trig   = ctl.tx_trig;

   AST_EXPORT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_we |=> ($stable(tx_trig) && $stable(loop_en) && $stable(tx_clear))); // R11

endmodule

// File: tb/rx_fifo_flowctl_tb.sv
module rx_fifo_flowctl_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0, rd_en = 1'b0, reg_we = 1'b0, flag_clr = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [15:0] reg_wdata = '0;
   logic [7:0]  rd_data;
   logic [15:0] reg_rdata;
   logic [6:0]  rx_count;
   logic        data_ready, rts_level, overrun, tx_clear, loop_en;
   logic [1:0]  tx_trig;

   always #5 clk = ~clk;

   rx_fifo_flowctl dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_en(rd_en), .rd_data(rd_data), .reg_we(reg_we),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flag_clr(flag_clr),
      .rx_count(rx_count), .data_ready(data_ready), .rts_level(rts_level),
      .overrun(overrun), .tx_clear(tx_clear), .loop_en(loop_en),
      .tx_trig(tx_trig)
   );

   int n_cmp = 0;
   int n_bad = 0;

   // Reference model state
   logic [7:0]  q[$];
   logic [15:0] m_ctl = '0;
   bit          m_rdy = 0, m_rts = 0, m_ovr = 0;

   function automatic int rts_thr(input logic [2:0] c);
      int t [8] = '{63, 1, 8, 16, 32, 48, 54, 60};
      return t[c];
   endfunction

   function automatic int rdy_thr(input logic [1:0] c);
      int t [4] = '{1, 16, 32, 48};
      return t[c];
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   // One clock: drive at negedge, model at posedge, compare at next negedge.
   task automatic cyc(input bit w, input logic [7:0] d, input bit r,
                      input bit rw, input logic [15:0] rv, input bit fc);
      int old;
      wr_en = w; wr_data = d; rd_en = r; reg_we = rw; reg_wdata = rv; flag_clr = fc;
      #1;
      if (r) begin
         if (q.size() > 0) chk(rd_data == q[0], "R8 rd_data", rd_data, q[0]);
         else              chk(rd_data == 8'h00, "R10 rd_data", rd_data, 0);
      end
      @(posedge clk);
      old   = q.size();
      m_rts = old > rts_thr(m_ctl[10:8]);
      m_rdy = (old >= rdy_thr(m_ctl[7:6])) || (m_rdy && !fc);
      if (m_ctl[1]) begin
         q.delete();
         m_ovr = 0;
      end else begin
         if (r && old > 0) void'(q.pop_front());
         if (w) begin
            if (old < 64) q.push_back(d);
            else          m_ovr = 1;
         end
      end
      if (rw) m_ctl = rv & 16'h07FF;
      @(negedge clk);
      wr_en = 0; rd_en = 0; reg_we = 0; flag_clr = 0;
      chk(rx_count == q.size(), "R8 count", rx_count, q.size());
      chk(rts_level == m_rts, "R3 rts", rts_level, m_rts);
      chk(data_ready == m_rdy, "R5 ready", data_ready, m_rdy);
      chk(overrun == m_ovr, "R9 overrun", overrun, m_ovr);
      chk(reg_rdata == m_ctl, "R1 reg", reg_rdata, m_ctl);
      chk({tx_trig, tx_clear, loop_en} == {m_ctl[5:4], m_ctl[2], m_ctl[0]},
          "R11 exports", {tx_trig, tx_clear, loop_en}, {m_ctl[5:4], m_ctl[2], m_ctl[0]});
   endtask

   task automatic idle();               cyc(0, 8'h00, 0, 0, 16'h0, 0); endtask
   task automatic push(input logic [7:0] d); cyc(1, d, 0, 0, 16'h0, 0); endtask
   task automatic pop();                cyc(0, 8'h00, 1, 0, 16'h0, 0); endtask
   task automatic wreg(input logic [15:0] v); cyc(0, 8'h00, 0, 1, v, 0); endtask
   task automatic flush_to(input logic [15:0] v);
      wreg(v | 16'h0002);
      wreg(v);
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      chk(reg_rdata == 16'h0000, "R1 reset reg", reg_rdata, 0);
      chk(rx_count == 0 && !data_ready && !rts_level && !overrun, "R1 reset outs",
          {rx_count, data_ready, rts_level, overrun}, 0);
      wreg(16'hFFFF);
      chk(reg_rdata == 16'h07FF, "R1 reserved", reg_rdata, 16'h07FF);
      chk(loop_en && tx_clear && tx_trig == 2'b11, "R11 set", {tx_trig, tx_clear, loop_en}, 4'hF);
      wreg(16'h0000);

      // R2 flow-control limits, strict comparison
      for (int c = 0; c < 8; c++) begin
         int lim;
         lim = rts_thr(3'(c));
         flush_to(16'(c) << 8);
         for (int i = 0; i < lim; i++) push(8'(i));
         idle();
         chk(rts_level == 0, "R2 at limit", rts_level, 0);
         push(8'hA5);
         idle();
         chk(rts_level == 1, "R2 above limit", rts_level, 1);
      end

      // R4 ready limits, >= comparison
      for (int c = 0; c < 4; c++) begin
         int lim;
         lim = rdy_thr(2'(c));
         flush_to(16'(c) << 6);
         cyc(0, 8'h00, 0, 0, 16'h0, 1);
         for (int i = 0; i < lim - 1; i++) push(8'(i + 3));
         idle();
         chk(data_ready == 0, "R4 below limit", data_ready, 0);
         push(8'h5A);
         idle();
         chk(data_ready == 1, "R4 at limit", data_ready, 1);
      end

      // R6 latch and clear rule (limit 16)
      flush_to(16'h0040);
      cyc(0, 8'h00, 0, 0, 16'h0, 1);
      for (int i = 0; i < 16; i++) push(8'(i));
      idle();
      cyc(0, 8'h00, 0, 0, 16'h0, 1);
      chk(data_ready == 1, "R6 clear ignored at limit", data_ready, 1);
      pop();
      idle();
      chk(data_ready == 1, "R6 held below limit", data_ready, 1);
      cyc(0, 8'h00, 0, 0, 16'h0, 1);
      chk(data_ready == 0, "R6 cleared", data_ready, 0);

      // R10 simultaneous read and write
      cyc(1, 8'h77, 1, 0, 16'h0, 0);
      chk(rx_count == 15, "R10 rd+wr count", rx_count, 15);

      // R7 flush holds count at zero and drops writes
      wreg(16'h0042);
      idle();
      chk(rx_count == 0, "R7 flushed", rx_count, 0);
      push(8'h99);
      chk(rx_count == 0, "R7 write dropped", rx_count, 0);
      wreg(16'h0040);
      chk(rx_count == 0, "R7 after release", rx_count, 0);

      // R8/R9 fill, overrun, ordered drain across wrap
      for (int i = 0; i < 30; i++) push(8'(i));
      for (int i = 0; i < 30; i++) pop();
      for (int i = 0; i < 64; i++) push(8'(8'h40 + i));
      push(8'hEE);
      chk(rx_count == 64, "R9 full count", rx_count, 64);
      chk(overrun == 1, "R9 overrun", overrun, 1);
      for (int i = 0; i < 64; i++) begin
         rd_en = 1; #1;
         chk(rd_data == 8'(8'h40 + i), "R8 order", rd_data, 8'h40 + i);
         pop();
      end
      pop();
      chk(rx_count == 0, "R10 empty read", rx_count, 0);
      chk(overrun == 1, "R9 sticky", overrun, 1);

      // Random traffic
      for (int n = 0; n < 4000; n++) begin
         bit w, r, rw, fc;
         logic [15:0] v;
         w  = ($urandom % 3) != 0;
         r  = ($urandom % 2) == 0;
         rw = ($urandom % 60) == 0;
         fc = ($urandom % 10) == 0;
         v  = 16'($urandom);
         if (($urandom % 4) != 0) v[1] = 1'b0;
         cyc(w, 8'($urandom), r, rw, v, fc);
      end

      finish_run();
   end

endmodule